// File: doc/BRIEF.md
# Parallel DAC Write-Cycle Sequencer

This block sits on the host side of an eight-channel, double-buffered DAC that has a parallel bus. It takes one command at a time on a valid/ready handshake and turns it into a correctly timed sequence on the DAC's active-low control lines: chip select, write, four pair-load strobes and a global clear. It also drives the 3-bit address and 13-bit data buses. There are three kinds of command. A channel write stores a signed value into one input latch and can also update that channel's output pair straight away. A pair load moves input latches to DAC latches for any subset of the four pairs at once. A clear resets every channel.

Each timing minimum is given in nanoseconds, together with the system clock period. The block derives every hold count from these values, so the same RTL can run at a different clock by changing parameters. The analog part is not modelled. The testbench observes the bus and measures each pulse and setup interval in clock cycles.

The reset input is asynchronous and active low. Its release is expected to be synchronous to `clk`.

Top module: `dac_bus_sequencer`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, all strobes (chip select, write, the four loads, clear) are high, `cmd_ready` is high, the address is 0 and the data bus holds 13'h1000 (mid-scale). Asserting reset in the middle of a command returns every strobe high at once.
- R2: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` then stays low until every strobe has been high again for one full cycle (the gap cycle), after which it returns high. For a write the number of ready-low cycles is C_AS + T_WR + 1, plus C_LD when `cmd_now` is set. For a pair load it is C_LD + 1. For a clear it is C_CLR + 1.
- R3: On a write (`cmd_op` = 2'b00) the data bus carries the two's-complement `cmd_value` converted to offset binary, which is `cmd_value` with bit 12 inverted. The bus holds that value from the cycle after acceptance until the next write is accepted.
- R4: On a write, the address bus carries `cmd_chan` from the cycle after acceptance. It is driven for C_AS cycles before write goes low and does not change while chip select is low.
- R5: Chip select and write fall in the same cycle and rise in the same cycle. They stay low for T_WR = max(C_WR, C_DS) cycles, so the data is stable for at least C_DS cycles before write rises.
- R6: A write with `cmd_now` = 1 drives load strobe `cmd_chan >> 1` low in the same cycle that write falls. It keeps that strobe low for C_LD further cycles after write and chip select rise. The other load strobes stay high.
- R7: A write with `cmd_now` = 0 leaves all four load strobes high.
- R8: A pair load (`cmd_op` = 2'b01) drives load strobe n low for exactly C_LD cycles for every n where `cmd_mask[n]` = 1, with all selected strobes in one common pulse. Write, chip select and clear stay high.
- R9: A clear (`cmd_op` = 2'b10) drives clear low for C_CLR cycles. Write, chip select and every load strobe stay high.
- R10: Each count is the ceiling of its nanosecond minimum divided by `CLK_PERIOD_NS`, and at least 1. With the defaults (5 ns clock; 50 ns select/write, 50 ns data setup, 10 ns address setup, 50 ns load, 100 ns clear) this gives C_WR = 10, C_DS = 10, C_AS = 2, C_LD = 10 and C_CLR = 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle, can accept a command |
| cmd_op | input | 2 | 00 channel write, 01 pair load, 10 clear |
| cmd_chan | input | CHAN_W | Channel number for a write |
| cmd_value | input | DATA_W | Signed two's-complement sample for a write |
| cmd_now | input | 1 | On a write, also update the channel's pair |
| cmd_mask | input | NPAIR | Pair selection for a pair load, bit n = pair n |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_wr_n | output | 1 | Write strobe, active low |
| dac_ld_n | output | NPAIR | Pair-load strobes, active low |
| dac_clr_n | output | 1 | Global clear, active low |
| dac_addr | output | CHAN_W | Input-latch address |
| dac_data | output | DATA_W | Offset-binary data bus |

## Verification
The bench checks the conversion at both extremes of the signed range and at zero, so that a sign-bit error shows up as a value off by half scale. It checks that a write with an immediate update keeps its load strobe low for a full load width after write rises. A design that released the load together with write would latch data that had not settled. Ready is counted cycle by cycle, so a missing gap cycle or an off-by-one timer shows up as a wrong count. A reset in the middle of a command must release every strobe at once, and a stuck load strobe fails that check.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_LOAD  = 2'd1,
    OP_CLEAR = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_STROBE,
    S_LDHOLD,
    S_LOAD,
    S_CLEAR,
    S_GAP
  } state_e;

  // ceiling of ns / period, never below one cycle
  function automatic int ns_to_cycles(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dacseq_timer.sv
module dacseq_timer #(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/dacseq_encode.sv
module dacseq_encode #(
  parameter int DATA_W = 13,
  parameter int CHAN_W = 3,
  localparam int NPAIR = 1 << (CHAN_W - 1)
) (
  input  logic [DATA_W-1:0] value,
  input  logic [CHAN_W-1:0] chan,
  output logic [DATA_W-1:0] code,
  output logic [NPAIR-1:0]  pair_oh
);

  // adding half scale to a two's-complement word flips only its top bit
  assign code = {~value[DATA_W-1], value[DATA_W-2:0]};

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign pair_oh[p] = (chan[CHAN_W-1:1] == (CHAN_W-1)'(p));
  end

endmodule

// File: rtl/dac_bus_sequencer.sv
module dac_bus_sequencer #(
  parameter int CLK_PERIOD_NS = 5,
  parameter int CSWR_MIN_NS   = 50,
  parameter int DSETUP_NS     = 50,
  parameter int ASETUP_NS     = 10,
  parameter int LOAD_MIN_NS   = 50,
  parameter int CLEAR_MIN_NS  = 100,
  parameter int DATA_W        = 13,
  parameter int CHAN_W        = 3,
  localparam int NPAIR        = 1 << (CHAN_W - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [CHAN_W-1:0] cmd_chan,
  input  logic [DATA_W-1:0] cmd_value,
  input  logic              cmd_now,
  input  logic [NPAIR-1:0]  cmd_mask,
  output logic              dac_cs_n,
  output logic              dac_wr_n,
  output logic [NPAIR-1:0]  dac_ld_n,
  output logic              dac_clr_n,
  output logic [CHAN_W-1:0] dac_addr,
  output logic [DATA_W-1:0] dac_data
);
  import dacseq_pkg::*;

  localparam int C_AS  = ns_to_cycles(ASETUP_NS,    CLK_PERIOD_NS);
  localparam int C_WR  = ns_to_cycles(CSWR_MIN_NS,  CLK_PERIOD_NS);
  localparam int C_DS  = ns_to_cycles(DSETUP_NS,    CLK_PERIOD_NS);
  localparam int C_LD  = ns_to_cycles(LOAD_MIN_NS,  CLK_PERIOD_NS);
  localparam int C_CLR = ns_to_cycles(CLEAR_MIN_NS, CLK_PERIOD_NS);
  localparam int T_WR  = max2(C_WR, C_DS);
  localparam int MAXC  = max2(max2(C_AS, T_WR), max2(C_LD, C_CLR));
  localparam int TW    = $clog2(MAXC + 1);
  localparam logic [DATA_W-1:0] MIDSCALE = DATA_W'(1) << (DATA_W - 1);

  state_e            st_q, st_d;
  logic [CHAN_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [NPAIR-1:0]  lsel_q, lsel_d;
  logic              cswr_lo_q, cswr_lo_d;
  logic [NPAIR-1:0]  ld_lo_q, ld_lo_d;
  logic              clr_lo_q, clr_lo_d;
  logic              t_load, t_zero;
  logic [TW-1:0]     t_val;
  logic [DATA_W-1:0] enc_code;
  logic [NPAIR-1:0]  enc_pair;

  dacseq_encode #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_enc (
    .value   (cmd_value),
    .chan    (cmd_chan),
    .code    (enc_code),
    .pair_oh (enc_pair)
  );

  dacseq_timer #(.TW(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  // next-state logic
  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    data_d = data_q;
    lsel_d = lsel_q;
    t_load = 1'b0;
    t_val  = '0;
    unique case (st_q)
      S_IDLE: begin
        if (cmd_valid) begin
          t_load = 1'b1;
          unique case (op_e'(cmd_op))
            OP_WRITE: begin
              st_d   = S_SETUP;
              t_val  = TW'(C_AS - 1);
              addr_d = cmd_chan;
              data_d = enc_code;
              lsel_d = cmd_now ? enc_pair : '0;
            end
            OP_LOAD: begin
              st_d   = S_LOAD;
              t_val  = TW'(C_LD - 1);
              lsel_d = cmd_mask;
            end
            OP_CLEAR: begin
              st_d  = S_CLEAR;
              t_val = TW'(C_CLR - 1);
            end
            default: st_d = S_GAP;
          endcase
        end
      end
      S_SETUP: if (t_zero) begin
        st_d = S_STROBE; t_load = 1'b1; t_val = TW'(T_WR - 1);
      end
      S_STROBE: if (t_zero) begin
        t_load = 1'b1;
        if (lsel_q != '0) begin
          st_d = S_LDHOLD; t_val = TW'(C_LD - 1);
        end else begin
          st_d = S_GAP;
        end
      end
      S_LDHOLD, S_LOAD, S_CLEAR: if (t_zero) begin
        st_d = S_GAP; t_load = 1'b1;
      end
      S_GAP: if (t_zero) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase

    cswr_lo_d = (st_d == S_STROBE);
    ld_lo_d   = (st_d == S_STROBE || st_d == S_LDHOLD || st_d == S_LOAD) ? lsel_d : '0;
    clr_lo_d  = (st_d == S_CLEAR);
  end

  // registers; strobes come straight from flops so they cannot glitch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      addr_q    <= '0;
      data_q    <= MIDSCALE;
      lsel_q    <= '0;
      cswr_lo_q <= 1'b0;
      ld_lo_q   <= '0;
      clr_lo_q  <= 1'b0;
    end else begin
      st_q      <= st_d;
      addr_q    <= addr_d;
      data_q    <= data_d;
      lsel_q    <= lsel_d;
      cswr_lo_q <= cswr_lo_d;
      ld_lo_q   <= ld_lo_d;
      clr_lo_q  <= clr_lo_d;
    end
  end

  assign cmd_ready = (st_q == S_IDLE);
  assign dac_cs_n  = ~cswr_lo_q;
  assign dac_wr_n  = ~cswr_lo_q;
  assign dac_ld_n  = ~ld_lo_q;
  assign dac_clr_n = ~clr_lo_q;
  assign dac_addr  = addr_q;
  assign dac_data  = data_q;

  // ---------------- assertions ----------------
  int  a_wr_cnt, a_ld_cnt, a_post_cnt, a_clr_cnt;
  logic a_ld_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_wr_cnt <= 0; a_ld_cnt <= 0; a_post_cnt <= 0; a_clr_cnt <= 0; a_ld_wr <= 1'b0;
    end else begin
      a_wr_cnt  <= dac_wr_n  ? 0 : a_wr_cnt + 1;
      a_clr_cnt <= dac_clr_n ? 0 : a_clr_cnt + 1;
      if (&dac_ld_n) begin
        a_ld_cnt <= 0; a_post_cnt <= 0; a_ld_wr <= 1'b0;
      end else begin
        a_ld_cnt <= a_ld_cnt + 1;
        if (dac_wr_n) a_post_cnt <= a_post_cnt + 1;
        else          a_ld_wr    <= 1'b1;
      end
    end
  end

  p_cs_with_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dac_cs_n == dac_wr_n);

  p_wr_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_wr_n) |-> a_wr_cnt >= T_WR);

  p_bus_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_cs_n && !$past(dac_cs_n)) |-> ($stable(dac_addr) && $stable(dac_data)));

  p_ld_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(&dac_ld_n) && a_ld_wr) |-> a_post_cnt >= C_LD);

  p_ld_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&dac_ld_n) |-> a_ld_cnt >= C_LD);

  p_clr_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_clr_n) |-> a_clr_cnt >= C_CLR);

  p_clr_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_clr_n |-> (dac_wr_n && (&dac_ld_n)));

  p_ready_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (dac_wr_n && dac_cs_n && dac_clr_n && (&dac_ld_n)));

endmodule

// File: tb/dac_bus_sequencer_test.sv
`timescale 1ns/1ps
module dac_bus_sequencer_test;

  localparam int PER = 5;
  function automatic int cyc(input int ns);
    int c;
    c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction
  localparam int E_AS  = cyc(10);
  localparam int E_WR  = (cyc(50) > cyc(50)) ? cyc(50) : cyc(50);
  localparam int E_LD  = cyc(50);
  localparam int E_CLR = cyc(100);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_ready, cmd_now;
  logic [1:0]  cmd_op;
  logic [2:0]  cmd_chan;
  logic [12:0] cmd_value;
  logic [3:0]  cmd_mask;
  logic        dac_cs_n, dac_wr_n, dac_clr_n;
  logic [3:0]  dac_ld_n;
  logic [2:0]  dac_addr;
  logic [12:0] dac_data;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dac_bus_sequencer #(
    .CLK_PERIOD_NS(5), .CSWR_MIN_NS(50), .DSETUP_NS(50), .ASETUP_NS(10),
    .LOAD_MIN_NS(50), .CLEAR_MIN_NS(100), .DATA_W(13), .CHAN_W(3)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_chan(cmd_chan), .cmd_value(cmd_value),
    .cmd_now(cmd_now), .cmd_mask(cmd_mask), .dac_cs_n(dac_cs_n),
    .dac_wr_n(dac_wr_n), .dac_ld_n(dac_ld_n), .dac_clr_n(dac_clr_n),
    .dac_addr(dac_addr), .dac_data(dac_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // fields: op[39:38] chan[37:35] value[34:22] now[21] mask[20:17] code[16:4] ld[3:0]
  localparam int NV = 9;
  localparam logic [39:0] VEC [NV] = '{
    {2'd0, 3'd0, 13'h0000, 1'b0, 4'h0, 13'h1000, 4'h0},
    {2'd0, 3'd1, 13'h0FFF, 1'b1, 4'h0, 13'h1FFF, 4'h1},
    {2'd0, 3'd2, 13'h1000, 1'b1, 4'h0, 13'h0000, 4'h2},
    {2'd0, 3'd5, 13'h1FFF, 1'b0, 4'h0, 13'h0FFF, 4'h0},
    {2'd0, 3'd7, 13'h0AAA, 1'b1, 4'h0, 13'h1AAA, 4'h8},
    {2'd1, 3'd0, 13'h0000, 1'b0, 4'h5, 13'h0000, 4'h5},
    {2'd1, 3'd0, 13'h0000, 1'b0, 4'hF, 13'h0000, 4'hF},
    {2'd2, 3'd0, 13'h0000, 1'b0, 4'h0, 13'h0000, 4'h0},
    {2'd0, 3'd6, 13'h0001, 1'b1, 4'h0, 13'h1001, 4'h8}
  };

  task automatic run_vec(input logic [39:0] v);
    logic [1:0]  op;
    logic [2:0]  ch;
    logic [12:0] code;
    logic [3:0]  eld, ldseen;
    logic        now;
    int n, wr_lo, mism, first_wr, last_wr, ld_cnt, last_ld, first_ld, clr_cnt, last_str;
    int data_bad, addr_bad, exp_n;
    op = v[39:38]; ch = v[37:35]; now = v[21]; code = v[16:4]; eld = v[3:0];
    n = 0; wr_lo = 0; mism = 0; first_wr = 0; last_wr = 0; ld_cnt = 0; last_ld = 0;
    first_ld = 0; clr_cnt = 0; last_str = 0; data_bad = 0; addr_bad = 0; ldseen = 4'h0;
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_chan = ch; cmd_value = v[34:22]; cmd_now = now; cmd_mask = v[20:17];
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 1; k <= 300; k++) begin
      if (cmd_ready) break;
      n = k;
      if (!dac_wr_n) begin
        wr_lo++; last_wr = k; last_str = k;
        if (first_wr == 0) first_wr = k;
      end
      if (dac_cs_n != dac_wr_n) mism++;
      if (dac_ld_n != 4'hF) begin
        ld_cnt++; ldseen = ldseen | ~dac_ld_n; last_ld = k; last_str = k;
        if (first_ld == 0) first_ld = k;
      end
      if (!dac_clr_n) begin clr_cnt++; last_str = k; end
      if (dac_data != code) data_bad++;
      if (dac_addr != ch) addr_bad++;
      @(negedge clk);
    end
    if (op == 2'd0) begin
      exp_n = E_AS + E_WR + (now ? E_LD : 0) + 1;
      chk(data_bad == 0, "R3 offset-binary data bus", int'(dac_data), int'(code));
      chk(addr_bad == 0, "R4 address bus", int'(dac_addr), int'(ch));
      chk(first_wr == E_AS + 1, "R4 R10 address setup before write", first_wr - 1, E_AS);
      chk(wr_lo == E_WR, "R5 R10 write low width", wr_lo, E_WR);
      chk(mism == 0, "R5 select/write together", mism, 0);
      chk(ldseen == eld, "R6 R7 load strobes used", int'(ldseen), int'(eld));
      if (now) begin
        chk(first_ld == first_wr, "R6 load falls with write", first_ld, first_wr);
        chk(last_ld == last_wr + E_LD, "R6 load hold after write", last_ld - last_wr, E_LD);
      end
    end else if (op == 2'd1) begin
      exp_n = E_LD + 1;
      chk(ldseen == eld && ld_cnt == E_LD, "R8 pair-load pulse", ld_cnt, E_LD);
      chk(wr_lo == 0 && clr_cnt == 0, "R8 other strobes quiet", wr_lo + clr_cnt, 0);
    end else begin
      exp_n = E_CLR + 1;
      chk(clr_cnt == E_CLR, "R9 R10 clear width", clr_cnt, E_CLR);
      chk(wr_lo == 0 && ld_cnt == 0, "R9 other strobes quiet", wr_lo + ld_cnt, 0);
    end
    chk(n == exp_n, "R2 ready-low cycles", n, exp_n);
    chk(last_str == n - 1, "R2 gap cycle before ready", n - last_str, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_chan = '0;
    cmd_value = '0; cmd_now = 1'b0; cmd_mask = '0;
    repeat (3) @(negedge clk);
    // R1 values during reset
    chk(dac_cs_n && dac_wr_n && dac_clr_n && dac_ld_n == 4'hF, "R1 strobes high in reset", 0, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready after reset", int'(cmd_ready), 1);
    chk(dac_addr == 3'd0, "R1 address after reset", int'(dac_addr), 0);
    chk(dac_data == 13'h1000, "R1 data after reset", int'(dac_data), 'h1000);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R1: reset in the middle of a write with immediate update
    cmd_op = 2'd0; cmd_chan = 3'd3; cmd_value = 13'h0123; cmd_now = 1'b1; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(!dac_wr_n && dac_ld_n == 4'hD, "R6 mid-write strobes low", int'(dac_ld_n), 'hD);
    #1 rst_n = 1'b0;
    #1;
    chk(dac_wr_n && dac_cs_n && dac_ld_n == 4'hF && dac_clr_n, "R1 async release of strobes",
        int'(dac_ld_n), 'hF);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && dac_data == 13'h1000, "R1 idle after mid-command reset", int'(dac_data), 'h1000);

    // the bus keeps working after the interrupted command
    run_vec({2'd0, 3'd4, 13'h1800, 1'b1, 4'h0, 13'h0800, 4'h4});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule